// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where instruction fetch goes after the current instruction on a 32-bit single-issue core with 32-bit fixed-length instructions. It takes the current program counter, the instruction word, and the two source register values already read for that instruction. From these it produces the next program counter, a redirect flag, and a request to write a return address into the link register. The block is purely combinational.

It covers these cases:

- **Straight-line flow.** The next PC is the current PC plus four.
- **Conditional branches.** Two compare-and-branch forms, one on equality and one on inequality. Each uses a signed 16-bit word offset that is added to the incremented PC.
- **Region jumps.** An unconditional jump and a jump-that-links, both using a 26-bit word address. The target keeps the top four bits of the current PC.
- **Register jump.** The next PC is loaded from the first source register.

Pipelining, prediction, delay slots and the register file all sit outside this block.

Top module: `npc_unit`

## Requirements
- R1: For any instruction that is not a branch or jump (any opcode other than 2, 3, 4 and 5, and opcode 0 with a function code other than 8), `next_pc_o` is `pc_i`+4 and `redirect_o` is low.
- R2: The equality branch has opcode 4 (bits 31:26), with the offset in bits 15:0. When `rs_val_i` equals `rt_val_i`, `next_pc_o` is `pc_i`+4 plus the sign-extended offset times four.
- R3: The inequality branch has opcode 5. When `rs_val_i` differs from `rt_val_i`, it goes to the same offset target as R2.
- R4: A branch whose condition fails gives `next_pc_o` = `pc_i`+4 with `redirect_o` low.
- R5: A branch offset with bit 15 set moves the PC backward. Sign extension covers the whole range, from -32768 words up to +32767 words.
- R6: The plain jump has opcode 2. Its target is `pc_i[31:28]`, followed by instruction bits 25:0, followed by two zero bits.
- R7: The linking jump has opcode 3 and goes to the same target as R6. It also raises `link_we_o`, with `link_rd_o` = 31 and `link_data_o` = `pc_i`+4.
- R8: The register jump is opcode 0 with function code 8 in bits 5:0. It sets `next_pc_o` to `rs_val_i`.
- R9: `redirect_o` is high for every taken branch and for every jump of the three jump kinds.
- R10: `link_we_o` is high only for the linking jump. At all other times it is low, and `link_rd_o` and `link_data_o` are zero.
- R11: Address arithmetic wraps modulo 2^32, so a PC of 0xFFFFFFFC steps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| next_pc_o | output | 32 | Address of the next instruction to fetch |
| redirect_o | output | 1 | High when the flow leaves the sequential path |
| link_we_o | output | 1 | Link-register write request |
| link_rd_o | output | 5 | Link destination register index |
| link_data_o | output | 32 | Return address to write |

## Verification
The assertions assume that instruction words are only ever sampled once the combinational inputs have settled. They place no constraint on which opcode arrives or on the register values. In particular, they do not assume word-aligned targets for the register jump.

The stimulus changes all inputs together, one vector per clock period, and checks results half a period later. It covers:

- opcodes outside the handled set;
- both branch polarities, taken and not taken;
- offsets at both extremes;
- jump address fields that are all ones;
- a PC at the top of the address space, where the sum must wrap.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN     = 32,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              redirect_o,
  output logic              link_we_o,
  output logic [REG_AW-1:0] link_rd_o,
  output logic [XLEN-1:0]   link_data_o
);

  localparam int OPC_W  = 6;
  localparam int IMM_W  = 16;
  localparam int ADDR_W = 26;
  localparam int HI_W   = XLEN - ADDR_W - 2;

  localparam logic [OPC_W-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OP_JMP     = 6'd2;
  localparam logic [OPC_W-1:0] OP_JLNK    = 6'd3;
  localparam logic [OPC_W-1:0] OP_BREQ    = 6'd4;
  localparam logic [OPC_W-1:0] OP_BRNE    = 6'd5;
  localparam logic [5:0]       FN_JREG    = 6'd8;

  logic [OPC_W-1:0]  opc;
  logic [5:0]        fn;
  logic [IMM_W-1:0]  imm;
  logic [ADDR_W-1:0] jaddr;
  logic [XLEN-1:0]   seq_pc, br_pc, jmp_pc;
  logic              is_beq, is_bne, is_j, is_jal, is_jr, regs_eq, br_taken;

  assign opc   = instr_i[XLEN-1 -: OPC_W];
  assign fn    = instr_i[5:0];
  assign imm   = instr_i[IMM_W-1:0];
  assign jaddr = instr_i[ADDR_W-1:0];

  assign is_beq = (opc == OP_BREQ);
  assign is_bne = (opc == OP_BRNE);
  assign is_j   = (opc == OP_JMP);
  assign is_jal = (opc == OP_JLNK);
  assign is_jr  = (opc == OP_SPECIAL) && (fn == FN_JREG);

  assign regs_eq  = (rs_val_i == rt_val_i);
  assign br_taken = (is_beq && regs_eq) || (is_bne && !regs_eq);

  assign seq_pc = pc_i + XLEN'(4);
  assign br_pc  = seq_pc + {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  assign jmp_pc = {pc_i[XLEN-1 -: HI_W], jaddr, 2'b00};

  always_comb begin
    if (is_jr)              next_pc_o = rs_val_i;
    else if (is_j || is_jal) next_pc_o = jmp_pc;
    else if (br_taken)       next_pc_o = br_pc;
    else                     next_pc_o = seq_pc;
  end

  assign redirect_o  = br_taken || is_j || is_jal || is_jr;
  assign link_we_o   = is_jal;
  assign link_rd_o   = is_jal ? REG_AW'(LINK_REG) : '0;
  assign link_data_o = is_jal ? seq_pc : '0;

  always_comb begin
    AST_SEQ_WHEN_NO_REDIRECT: assert (redirect_o || next_pc_o == pc_i + XLEN'(4))
      else $error("sequential pc broken"); // R1
    AST_BRANCH_FOLLOWS_COMPARE: assert (!(is_beq || is_bne) || (redirect_o == (is_beq ~^ regs_eq)))
      else $error("branch condition mismatch"); // R4
    AST_JUMP_KEEPS_REGION: assert (!(is_j || is_jal) ||
        (next_pc_o[XLEN-1 -: HI_W] == pc_i[XLEN-1 -: HI_W] && next_pc_o[1:0] == 2'b00))
      else $error("jump left region"); // R6
    AST_LINK_ONLY_JAL: assert (!link_we_o || (redirect_o && link_rd_o == REG_AW'(LINK_REG)
        && link_data_o == pc_i + XLEN'(4)))
      else $error("link request malformed"); // R7
    AST_LINK_IDLE_ZERO: assert (link_we_o || (link_rd_o == '0 && link_data_o == '0))
      else $error("idle link not zero"); // R10
    AST_JR_TARGET: assert (!is_jr || (redirect_o && next_pc_o == rs_val_i))
      else $error("register jump target"); // R8
  end

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] pc, instr, rs_v, rt_v, npc, ldata;
  logic        redir, lwe;
  logic [4:0]  lrd;

  npc_unit u_npc_unit (
    .pc_i(pc), .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v),
    .next_pc_o(npc), .redirect_o(redir), .link_we_o(lwe),
    .link_rd_o(lrd), .link_data_o(ldata)
  );

  int checks = 0;
  int fails  = 0;

  // {pc, instr, rs, rt, expected next pc, expected redirect, expected link}
  localparam int NV = 16;
  localparam logic [161:0] VEC [NV] = '{
    {32'h0001_3880, 32'h0232_4020, 32'h1,   32'h2,   32'h0001_3884, 1'b0, 1'b0}, // R1 alu op
    {32'h0001_388C, 32'h1515_0002, 32'h1,   32'h2,   32'h0001_3898, 1'b1, 1'b0}, // R3 bne taken
    {32'h0001_388C, 32'h1515_0002, 32'h7,   32'h7,   32'h0001_3890, 1'b0, 1'b0}, // R4 bne not taken
    {32'h0001_388C, 32'h1115_0002, 32'h9,   32'h9,   32'h0001_3898, 1'b1, 1'b0}, // R2 beq taken
    {32'h0001_388C, 32'h1115_0002, 32'h9,   32'hA,   32'h0001_3890, 1'b0, 1'b0}, // R4 beq not taken
    {32'h0000_1000, 32'h1000_FFFD, 32'h0,   32'h0,   32'h0000_0FF8, 1'b1, 1'b0}, // R5 backward
    {32'h0001_3894, 32'h0800_4E20, 32'h5,   32'h6,   32'h0001_3880, 1'b1, 1'b0}, // R6 jump
    {32'hA000_0010, 32'h0BFF_FFFF, 32'h0,   32'h0,   32'hAFFF_FFFC, 1'b1, 1'b0}, // R6 region kept
    {32'h0040_0020, 32'h0C00_0100, 32'h123, 32'h456, 32'h0000_0400, 1'b1, 1'b1}, // R7 jal
    {32'h0000_0800, 32'h03E0_0008, 32'h0040_0024, 32'h0, 32'h0040_0024, 1'b1, 1'b0}, // R8 jr
    {32'h0000_0800, 32'h03E0_0009, 32'h0040_0024, 32'h0, 32'h0000_0804, 1'b0, 1'b0}, // R1 other funct
    {32'hFFFF_FFFC, 32'h0232_4020, 32'h0,   32'h0,   32'h0000_0000, 1'b0, 1'b0}, // R11 wrap
    {32'hFFFF_FFFC, 32'h1000_0000, 32'h3,   32'h3,   32'h0000_0000, 1'b1, 1'b0}, // R11 branch wrap
    {32'h0000_2000, 32'hAC00_0000, 32'h0,   32'h0,   32'h0000_2004, 1'b0, 1'b0}, // R1 store opcode
    {32'h0000_0000, 32'h1420_7FFF, 32'h1,   32'h0,   32'h0002_0000, 1'b1, 1'b0}, // R5 max forward
    {32'h0002_0000, 32'h1000_8000, 32'h4,   32'h4,   32'h0000_0004, 1'b1, 1'b0}  // R5 max backward
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    pc = p; instr = i; rs_v = a; rt_v = b;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pc = '0; instr = '0; rs_v = '0; rt_v = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle state: all-zero instruction behaves sequentially, no link (R1, R10)
    chk(npc == 32'h4, "R1 idle next pc", npc, 32'h4);
    chk(!redir && !lwe && lrd == 5'd0 && ldata == 32'h0, "R10 idle link", {lwe, lrd, ldata[25:0]}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [31:0] vpc, vin, va, vb, ve;
      logic        vr, vl;
      {vpc, vin, va, vb, ve, vr, vl} = VEC[k];
      apply(vpc, vin, va, vb);
      chk(npc == ve, $sformatf("R2/R3/R6/R8 vec%0d next pc", k), npc, ve);
      chk(redir == vr, $sformatf("R9 vec%0d redirect", k), {31'b0, redir}, {31'b0, vr});
      chk(lwe == vl, $sformatf("R10 vec%0d link we", k), {31'b0, lwe}, {31'b0, vl});
      if (vl) begin
        chk(lrd == 5'd31, "R7 link reg", {27'b0, lrd}, 32'd31);
        chk(ldata == vpc + 32'd4, "R7 link data", ldata, vpc + 32'd4);
      end else begin
        chk(lrd == 5'd0 && ldata == 32'h0, "R10 link zero", ldata, 32'h0);
      end
    end

    // jal target ignores register values (R7)
    apply(32'h3000_0000, 32'h0C00_0001, 32'hFFFF_FFFF, 32'h0);
    chk(npc == 32'h3000_0004, "R7 jal ignores regs", npc, 32'h3000_0004);
    chk(ldata == 32'h3000_0004, "R7 jal link data", ldata, 32'h3000_0004);
    // beq compare uses full width: differing only in bit 31 (R4)
    apply(32'h100, 32'h1000_0010, 32'h8000_0000, 32'h0);
    chk(npc == 32'h104 && !redir, "R4 msb differ", npc, 32'h104);
    // bne with upper-bit difference taken (R3)
    apply(32'h100, 32'h1400_0010, 32'h8000_0000, 32'h0);
    chk(npc == 32'h144 && redir, "R3 msb differ", npc, 32'h144);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule